// File: doc/BRIEF.md
# Synchronous Presettable Binary Counter

This block is a small binary up counter. Every change of its state happens on the rising edge of one clock, and that includes clearing it and loading it. An active-low clear input forces the count to zero at the next edge. An active-low load input copies a data word into the count at the next edge. When neither is asserted, the count advances by one only if two separate count enables are both high. One enable is a plain gate. The other also qualifies the carry output, so it can be wired to the carry of a lower stage.

The carry output is a look-ahead terminal-count signal. It is combinational and is high when the count sits at its maximum and the trickle enable is high. Several counters can be cascaded by feeding each stage's carry into the trickle enable of the next stage. Every stage shares the clock, clear, load and parallel enable, so the chained counters still change state on one edge with no ripple between stages. The default width is 4 bits, so the count runs 0 to 15.

Top module: `presettable_counter`

## Requirements
- R1: The count changes only at a rising clock edge; between edges it stays at the value taken at the last edge, whatever the inputs do.
- R2: When `clr_n` is 0 at a rising edge, the count becomes 0 after that edge, regardless of `load_n`, `data_in` and both enables; the count does not change before the edge.
- R3: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `data_in` is copied into the count, regardless of both count enables.
- R4: When `clr_n` and `load_n` are both 1 and `en_par` and `en_trk` are both 1, the count increases by one at the edge.
- R5: An enabled increment from the all-ones value (15 for width 4) gives 0.
- R6: When `clr_n` and `load_n` are both 1 and either enable is 0, the count holds.
- R7: `carry_out` is 1 exactly when the count is all ones and `en_trk` is 1, in the same cycle, with no clock edge in between.
- R8: Two instances that share clock, clear, load and `en_par`, with the low stage's `carry_out` driving the high stage's `en_trk`, count as one 8-bit counter through all 256 states and wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| data_in | input | WIDTH | Value loaded when `load_n` is 0 |
| en_par | input | 1 | Count enable that gates counting only |
| en_trk | input | 1 | Count enable that also qualifies `carry_out` |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal count: count all ones and `en_trk` high |

## Verification
The bench goes after the priority corners: clear held together with load and both enables, and load held together with both enables. A design with the wrong priority would load or count there instead of zeroing or loading. It checks that the count has not moved in the half cycle after clear is driven low. A design with an asynchronous clear would show zero too early. It also drops each enable alone at the all-ones value. A carry that ignores the trickle enable, or a counter that needs only one enable, would then carry or wrap falsely. Finally, it runs an 8-bit chain through 256 states. A late (registered) carry would make the high stage step one cycle after the low stage wraps, or not step at all.

// File: rtl/presettable_counter.sv
module presettable_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data_in,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);

  logic             advance;
  logic [WIDTH-1:0] flip;

  assign advance = clr_n & load_n & en_par & en_trk;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_flip
      if (i == 0) begin : g_lsb
        assign flip[i] = advance;
      end else begin : g_upper
        assign flip[i] = advance & (&count[i-1:0]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!clr_n)       count <= '0;
    else if (!load_n) count <= data_in;
    else              count <= count ^ flip;
  end

  assign carry_out = en_trk & (&count);

endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] data_in,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!started)
    !clr_n |=> count == '0); // R2

  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!started)
    (clr_n && !load_n) |=> count == $past(data_in)); // R3

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!started)
    (clr_n && load_n && en_par && en_trk) |=> count == WIDTH'($past(count) + 1'b1)); // R4

  AST_WRAP_ON_CARRY: assert property (@(posedge clk) disable iff (!started)
    (clr_n && load_n && en_par && carry_out) |=> count == '0); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!started)
    (clr_n && load_n && !(en_par && en_trk)) |=> $stable(count)); // R6

  AST_CARRY_AT_MAX: assert property (@(posedge clk) disable iff (!started)
    (en_trk && count == {WIDTH{1'b1}}) |-> carry_out); // R7

  AST_CARRY_NEEDS_TRK: assert property (@(posedge clk) disable iff (!started)
    !en_trk |-> !carry_out); // R7

endmodule

bind presettable_counter presettable_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_in),
  .en_par(en_par), .en_trk(en_trk), .count(count), .carry_out(carry_out)
);

// File: tb/presettable_counter_test.sv
module presettable_counter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [7:0] din = 8'h00;
  logic [3:0] cnt_lo, cnt_hi;
  logic       c_lo, c_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  presettable_counter #(.WIDTH(4)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(din[3:0]),
    .en_par(en_par), .en_trk(en_trk), .count(cnt_lo), .carry_out(c_lo));

  presettable_counter #(.WIDTH(4)) uut_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(din[7:4]),
    .en_par(en_par), .en_trk(c_lo), .count(cnt_hi), .carry_out(c_hi));

  typedef struct {
    logic [7:0] val;
    logic       cl;
    logic       ch;
    string      req;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;
  logic [3:0] m_lo, m_hi;
  bit m_valid = 0;

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic drive(input bit r, input bit l, input logic [7:0] d,
                       input bit ep, input bit et, input string req);
    logic [3:0] n_lo, n_hi;
    bit t_hi;
    item_t it;
    @(negedge clk);
    clr_n = r; load_n = l; din = d; en_par = ep; en_trk = et;
    #1;
    if (m_valid) begin
      compared++;
      if ({cnt_hi, cnt_lo} !== {m_hi, m_lo}) begin
        mismatched++;
        $display("FAIL R1/R2 count moved before edge: act=%h exp=%h", {cnt_hi, cnt_lo}, {m_hi, m_lo});
      end
    end
    t_hi = et && (m_lo == 4'hF);
    if (!r)                n_lo = 4'h0;
    else if (!l)           n_lo = d[3:0];
    else if (ep && et)     n_lo = m_lo + 4'h1;
    else                   n_lo = m_lo;
    if (!r)                n_hi = 4'h0;
    else if (!l)           n_hi = d[7:4];
    else if (ep && t_hi)   n_hi = m_hi + 4'h1;
    else                   n_hi = m_hi;
    m_lo = n_lo; m_hi = n_hi; m_valid = 1;
    it.val = {n_hi, n_lo};
    it.cl  = et && (n_lo == 4'hF);
    it.ch  = it.cl && (n_hi == 4'hF);
    it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        compared++;
        if ({cnt_hi, cnt_lo} !== it.val) begin
          mismatched++;
          $display("FAIL %s count: act=%h exp=%h", it.req, {cnt_hi, cnt_lo}, it.val);
        end
        compared++;
        if ({c_hi, c_lo} !== {it.ch, it.cl}) begin
          mismatched++;
          $display("FAIL R7 carry (%s): act=%b exp=%b", it.req, {c_hi, c_lo}, {it.ch, it.cl});
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin : stimulus
    drive(0, 1, 8'h00, 0, 0, "R2 reset");
    drive(0, 1, 8'h00, 1, 1, "R2 reset");
    drive(1, 0, 8'hA5, 0, 0, "R3 load enables low");
    drive(1, 1, 8'h00, 0, 1, "R6 hold en_par low");
    drive(1, 1, 8'h00, 1, 0, "R6 hold en_trk low");
    drive(0, 0, 8'h3C, 1, 1, "R2 clear beats load");
    drive(1, 0, 8'h7E, 1, 1, "R3 load beats count");
    drive(1, 1, 8'h00, 1, 1, "R1 R4 step 7E->7F");
    drive(1, 1, 8'h00, 1, 1, "R5 R8 low wrap carries 7F->80");
    drive(1, 0, 8'h0E, 0, 1, "R3 load 0E");
    drive(1, 1, 8'h00, 1, 1, "R4 step to 0F");
    drive(1, 1, 8'h00, 0, 1, "R6 R7 hold at F, carry high");
    drive(1, 1, 8'h00, 1, 0, "R6 R7 hold at F, carry low");
    drive(1, 1, 8'h00, 1, 1, "R5 wrap low stage");
    drive(1, 0, 8'h00, 0, 0, "R3 load zero");
    for (int i = 0; i < 256; i++) drive(1, 1, 8'h00, 1, 1, "R8 chain count");
    drive(1, 0, 8'hFF, 0, 1, "R3 load FF");
    drive(1, 1, 8'h00, 0, 1, "R7 chain carry at FF");
    drive(0, 1, 8'h00, 1, 1, "R2 clear from FF");
    @(posedge clk);
    #2;
    wait (q.size() == 0);
    report();
    $finish;
  end
endmodule